// File: doc/BRIEF.md
# Cascaded Serial Sink-Driver Frame Loader

This block sits on the host side of a string of cascaded 8-bit serial-in, latched, constant-current sink drivers. It takes one frame word of `CHAIN*8` bits over a valid/ready handshake. It then produces the four signals that the chain needs: serial data, a shift clock, a latch strobe and an active-low output enable. Every edge is placed with a minimum interval that is set as a count of system-clock cycles. These intervals are data setup before the first rising edge, the clock high and low phases, the gap before the strobe, the strobe width and the minimum blanking width. A dense chain can be driven at its limit, and a slow chain is covered by changing only the parameters.

The frame is shifted most significant bit first. Each shift moves data one stage toward the far end of the chain, so bit `CHAIN*8-1` ends up in the last stage of the device farthest from the host. After the last bit comes a latch strobe, and then a one-cycle `done` pulse. If `blank_en` is high when a frame is accepted, the output enable is driven high (drivers off) from the first data bit until the strobe has ended. It also stays high for at least the minimum blanking width. This mode is the one to use when the latches are left transparent.

Back-pressure rules: `frame_ready` is high only when the block is fully idle. A frame is taken on any clock edge where `frame_valid` and `frame_ready` are both high. `frame_data` and `blank_en` are sampled on that edge only. `frame_valid` may be held high while the block is busy; it is then ignored until `frame_ready` returns.

Top module: `chain_loader`

## Requirements
- R1: `frame_ready` is high exactly when `busy` is low. A frame is accepted on an edge with `frame_valid` and `frame_ready` both high. While `busy` is high, `frame_valid` and `frame_data` have no effect.
- R2: `ser_data` carries bit `CHAIN*8-1` first and then the lower bits in descending order. The first bit is presented for `SETUP_CYC` cycles before the first clock rise. Data changes only on the cycle the clock falls, so each bit is stable for the whole high phase. After the last fall, `ser_data` is 0.
- R3: each frame gives exactly `CHAIN*8` clock pulses. Each pulse is high for `HIGH_CYC` cycles, followed by `LOW_CYC` low cycles.
- R4: `latch_str` goes high `LOW_CYC+GAP_CYC` cycles after the last clock fall and stays high for `LATCH_CYC` cycles. It is never high in the same cycle as `ser_clk`.
- R5: `done` is high for exactly one cycle, directly after the strobe ends. The sequence is then idle.
- R6: for a frame accepted with `blank_en` low, `oe_n` stays low throughout.
- R7: for a frame accepted with `blank_en` high, `oe_n` goes high in the cycle after acceptance. It stays high through the `done` cycle and for at least `BLANK_CYC` cycles in total: exactly max(frame length, `BLANK_CYC`) cycles.
- R8: `busy` is high from the cycle after acceptance until both the sequence has ended and `oe_n` has been released.
- R9: after reset, `ser_clk`, `ser_data`, `latch_str`, `done`, `busy` and `oe_n` are low and `frame_ready` is high.
- R10: a change of `blank_en` after a frame has been accepted has no effect on that frame's blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blank_en | input | 1 | Blank outputs during entry for the frame being accepted |
| frame_data | input | CHAIN*8 | Frame word, MSB goes to the farthest device |
| frame_valid | input | 1 | Frame word is offered |
| frame_ready | output | 1 | Block is idle and will take a frame |
| ser_data | output | 1 | Serial data to the first device |
| ser_clk | output | 1 | Shift clock, data taken on its rising edge |
| latch_str | output | 1 | Latch strobe, active high |
| oe_n | output | 1 | Output enable, low turns drivers on |
| busy | output | 1 | Frame in progress or blanking still held |
| done | output | 1 | One-cycle pulse when the frame is latched |

## Verification
The assertions assume that every timing count parameter is at least 1. They also assume that `frame_valid`, `frame_data` and `blank_en` are synchronous to `clk`, because each is sampled only on the acceptance edge and no assertion guards a metastable input. The stimulus changes inputs only on the falling edge. It sometimes holds `frame_valid` high through a busy period and toggles `blank_en` in the middle of a frame, but it always offers complete frames. This keeps every acceptance a single well-defined edge.

// File: rtl/loader_pkg.sv
package loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_CLK_HI = 3'd2,
    ST_CLK_LO = 3'd3,
    ST_GAP    = 3'd4,
    ST_LATCH  = 3'd5,
    ST_DONE   = 3'd6
  } ldr_state_t;
endpackage

// File: rtl/ldr_timer.sv
module ldr_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ldr_shifter.sv
module ldr_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] data,
  input  logic         shift,
  output logic         sdo,
  output logic         empty
);
  localparam int BW = $clog2(W + 1);

  logic [W-1:0]  shreg;
  logic [BW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (load) begin
      shreg <= data;
      left  <= BW'(W);
    end else if (shift) begin
      shreg <= {shreg[W-2:0], 1'b0};
      left  <= left - 1'b1;
    end
  end

  assign sdo   = shreg[W-1];
  assign empty = (left == '0);

  // R3: a shift is never requested once all bits are out
  p_shift_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !empty);
endmodule

// File: rtl/ldr_blank.sv
module ldr_blank #(
  parameter int BLANK_CYC = 450
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic blank_en,
  input  logic seq_finished,
  output logic oe_n
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_n <= 1'b0;
      bcnt <= '0;
    end else if (accept && blank_en) begin
      oe_n <= 1'b1;
      bcnt <= BW'(1);
    end else if (oe_n) begin
      if (seq_finished && (bcnt >= BW'(BLANK_CYC)))
        oe_n <= 1'b0;
      else if (bcnt != BW'(BLANK_CYC))
        bcnt <= bcnt + 1'b1;
    end
  end

  // R7: blanking is never released before the strobe has ended
  p_oe_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && !seq_finished) |=> oe_n);
  // R7: release only after the minimum blanking width
  p_oe_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> ($past(bcnt) == BW'(BLANK_CYC)));
  // R6: without a blanked acceptance, output enable stays low
  p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !(accept && blank_en)) |=> !oe_n);
endmodule

// File: rtl/ldr_seq.sv
module ldr_seq
  import loader_pkg::*;
#(
  parameter int SETUP_CYC = 5,
  parameter int HIGH_CYC  = 5,
  parameter int LOW_CYC   = 5,
  parameter int GAP_CYC   = 2,
  parameter int LATCH_CYC = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       empty,
  output ldr_state_t state,
  output logic       shift,
  output logic       ser_clk,
  output logic       latch_str,
  output logic       done
);
  localparam int M1   = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int M2   = (LOW_CYC > GAP_CYC) ? LOW_CYC : GAP_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXD = (M3 > LATCH_CYC) ? M3 : LATCH_CYC;
  localparam int CW   = (MAXD < 2) ? 1 : $clog2(MAXD);

  ldr_state_t state_n;
  logic       expired;
  logic       tload;
  logic [CW-1:0] tval;

  function automatic logic [CW-1:0] dur_m1(input ldr_state_t s);
    case (s)
      ST_SETUP:  dur_m1 = CW'(SETUP_CYC - 1);
      ST_CLK_HI: dur_m1 = CW'(HIGH_CYC - 1);
      ST_CLK_LO: dur_m1 = CW'(LOW_CYC - 1);
      ST_GAP:    dur_m1 = CW'(GAP_CYC - 1);
      ST_LATCH:  dur_m1 = CW'(LATCH_CYC - 1);
      default:   dur_m1 = '0;
    endcase
  endfunction

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE:   if (accept)  state_n = ST_SETUP;
      ST_SETUP:  if (expired) state_n = ST_CLK_HI;
      ST_CLK_HI: if (expired) state_n = ST_CLK_LO;
      ST_CLK_LO: if (expired) state_n = empty ? ST_GAP : ST_CLK_HI;
      ST_GAP:    if (expired) state_n = ST_LATCH;
      ST_LATCH:  if (expired) state_n = ST_DONE;
      ST_DONE:   state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  assign tload = (state_n != state);
  assign tval  = dur_m1(state_n);

  ldr_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tload),
    .load_val (tval),
    .expired  (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_n;
  end

  assign shift     = (state == ST_CLK_HI) && (state_n == ST_CLK_LO);
  assign ser_clk   = (state == ST_CLK_HI);
  assign latch_str = (state == ST_LATCH);
  assign done      = (state == ST_DONE);

  // R4: the strobe starts only after every bit has been shifted
  p_latch_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_str) |-> empty);
  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/chain_loader.sv
module chain_loader
  import loader_pkg::*;
#(
  parameter int CHAIN     = 2,
  parameter int SETUP_CYC = 5,
  parameter int HIGH_CYC  = 5,
  parameter int LOW_CYC   = 5,
  parameter int GAP_CYC   = 2,
  parameter int LATCH_CYC = 10,
  parameter int BLANK_CYC = 450
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               blank_en,
  input  logic [CHAIN*8-1:0] frame_data,
  input  logic               frame_valid,
  output logic               frame_ready,
  output logic               ser_data,
  output logic               ser_clk,
  output logic               latch_str,
  output logic               oe_n,
  output logic               busy,
  output logic               done
);
  localparam int W = CHAIN * 8;

  ldr_state_t state;
  logic       accept;
  logic       shift;
  logic       empty;
  logic       seq_finished;

  assign frame_ready  = !busy;
  assign accept       = frame_valid && frame_ready;
  assign seq_finished = (state == ST_DONE) || (state == ST_IDLE);
  assign busy         = (state != ST_IDLE) || oe_n;

  ldr_seq #(
    .SETUP_CYC (SETUP_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .LOW_CYC   (LOW_CYC),
    .GAP_CYC   (GAP_CYC),
    .LATCH_CYC (LATCH_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .empty     (empty),
    .state     (state),
    .shift     (shift),
    .ser_clk   (ser_clk),
    .latch_str (latch_str),
    .done      (done)
  );

  ldr_shifter #(.W(W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .data  (frame_data),
    .shift (shift),
    .sdo   (ser_data),
    .empty (empty)
  );

  ldr_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .blank_en     (blank_en),
    .seq_finished (seq_finished),
    .oe_n         (oe_n)
  );

  // R1: an accepted frame makes the block busy on the next cycle
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R2: serial data never moves while the shift clock is high
  p_data_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));
  // R4: strobe and shift clock are mutually exclusive
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_clk && latch_str));
endmodule

// File: tb/sim_chain_loader.sv
module sim_chain_loader;
  localparam int CHAIN = 2;
  localparam int W     = CHAIN * 8;
  localparam int S  = 5;
  localparam int H  = 5;
  localparam int L  = 5;
  localparam int G  = 2;
  localparam int P  = 10;
  localparam int BC = 450;

  typedef struct packed {
    logic sclk;
    logic sdata;
    logic latch;
    logic dn;
    logic oe;
    logic bsy;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         blank_en = 1'b0;
  logic [W-1:0] frame_data = '0;
  logic         frame_valid = 1'b0;
  logic         frame_ready, ser_data, ser_clk, latch_str, oe_n, busy, done;

  int   checks = 0;
  int   failures = 0;
  int   cycles = 0;
  bit   finished = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  chain_loader #(
    .CHAIN(CHAIN), .SETUP_CYC(S), .HIGH_CYC(H), .LOW_CYC(L),
    .GAP_CYC(G), .LATCH_CYC(P), .BLANK_CYC(BC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .blank_en(blank_en), .frame_data(frame_data),
    .frame_valid(frame_valid), .frame_ready(frame_ready), .ser_data(ser_data),
    .ser_clk(ser_clk), .latch_str(latch_str), .oe_n(oe_n), .busy(busy), .done(done)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural expected trace of one frame, one entry per cycle after acceptance
  task automatic build_trace(input logic [W-1:0] d, input logic blk);
    int t0, total, oeh, len;
    t0    = S + W * (H + L) + G + P;
    total = t0 + 1;
    oeh   = blk ? ((total > BC) ? total : BC) : 0;
    len   = (total > oeh) ? total : oeh;
    for (int c = 0; c < len; c++) begin
      exp_t e;
      e = '0;
      if (c < total) begin
        e.bsy = 1'b1;
        if (c < S) e.sdata = d[W-1];
        else if (c - S < W * (H + L)) begin
          int k, r, b;
          k = (c - S) / (H + L);
          r = (c - S) % (H + L);
          b = W - 1 - k;
          if (r < H) begin
            e.sclk  = 1'b1;
            e.sdata = d[b];
          end else begin
            e.sdata = (b > 0) ? d[b-1] : 1'b0;
          end
        end else if (c - S - W * (H + L) < G) begin
          e.sdata = 1'b0;
        end else if (c - S - W * (H + L) < G + P) begin
          e.latch = 1'b1;
        end else begin
          e.dn = 1'b1;
        end
      end
      e.oe = (c < oeh);
      if (c < oeh) e.bsy = 1'b1;
      q.push_back(e);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && frame_valid && frame_ready) build_trace(frame_data, blank_en);
  end

  // Compare every cycle against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      exp_t e;
      e = (q.size() > 0) ? q.pop_front() : '0;
      check_bit("R3 ser_clk", ser_clk, e.sclk);
      check_bit("R2 ser_data", ser_data, e.sdata);
      check_bit("R4 latch_str", latch_str, e.latch);
      check_bit("R5 done", done, e.dn);
      check_bit(e.oe ? "R7 oe_n" : "R6 oe_n", oe_n, e.oe);
      check_bit("R8 busy", busy, e.bsy);
      check_bit("R1 frame_ready", frame_ready, !e.bsy);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic send(input logic [W-1:0] d, input logic blk);
    @(negedge clk);
    frame_data  = d;
    blank_en    = blk;
    frame_valid = 1'b1;
    while (!frame_ready) @(negedge clk);
    @(negedge clk);
    frame_valid = 1'b0;
    frame_data  = ~d;
  endtask

  task automatic wait_idle();
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: reset values
    check_bit("R9 ser_clk", ser_clk, 1'b0);
    check_bit("R9 ser_data", ser_data, 1'b0);
    check_bit("R9 latch_str", latch_str, 1'b0);
    check_bit("R9 done", done, 1'b0);
    check_bit("R9 busy", busy, 1'b0);
    check_bit("R9 oe_n", oe_n, 1'b0);
    check_bit("R9 frame_ready", frame_ready, 1'b1);

    send(16'hA5C3, 1'b0);              // R2 R3 R4 R5 R6
    wait_idle();
    send(16'hFFFF, 1'b1);              // R7 with blanking longer than frame
    wait_idle();
    send(16'h0000, 1'b0);
    wait_idle();

    // R1: second frame held valid through the busy period
    send(16'h8001, 1'b1);
    send(16'h7FFE, 1'b0);
    wait_idle();

    // R10: blank_en dropped mid frame must not shorten blanking
    begin
      int hi;
      hi = 0;
      send(16'h1234, 1'b1);
      blank_en = 1'b0;
      hi = 1;  // oe_n was high on the acceptance-following cycle already sampled
      while (busy) begin
        @(negedge clk);
        if (oe_n) hi++;
      end
      check_bit("R10 blanking width kept", (hi == BC), 1'b1);
      if (hi != BC) $display("FAIL R10 actual=%0d expected=%0d", hi, BC);
    end
    wait_idle();

    for (int i = 0; i < W; i += 5) begin
      send(16'h0001 << i, 1'b0);
      wait_idle();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule